// File: doc/BRIEF.md
# SDRAM Single-Word Read Sequencer

This block owns an SDRAM command bus for the purpose of fetching one data word at a time. A request carries a bank, a row and a column. The sequencer opens the row with an ACTIVE command. It then issues a READ with the auto-precharge address bit held low and registers the returned word once the CAS latency has elapsed. Finally it closes the bank with an explicit single-bank PRECHARGE. The word is handed back together with a one-cycle completion pulse.

All device timing minimums are given as parameters in picoseconds, alongside the clock period. At elaboration each one is converted to a whole number of clock cycles, rounded up. Every constraint then has its own small down-counter. The row-cycle counter runs from ACTIVE to ACTIVE and is independent of the precharge counter, so the longer of the two windows always governs the next row opening. The burst length is one. Clock enable stays high and the data mask stays low.

Top module: `sdram_rd_seq`

## Requirements
- R1: After synchronous reset the bus shows NOP, `done` is low and `req_ready` is high. Command codes are {cs_n,ras_n,cas_n,we_n}: NOP=0111, ACTIVE=0011, READ=0101, PRECHARGE=0010.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. In the cycle that follows, ACTIVE is on the bus, with `sd_ba` set to the request bank and `sd_addr` set to the zero-extended row.
- R3: READ appears exactly ceil(tRCD/period) cycles after ACTIVE (2 at the defaults). It carries the same bank. The column sits in the low address bits, and every higher address bit is 0, including bit 10 (auto precharge off).
- R4: DQ is captured on the rising edge that ends CAS_LAT cycles after the edge that presents READ to the memory. `done` rises in the cycle after that edge and `done_data` holds the word; at the defaults this is 5 cycles after ACTIVE.
- R5: PRECHARGE targets the open bank with address bit 10 low. It comes no sooner than ceil(tRAS/period) cycles after ACTIVE and no sooner than the data capture. At the defaults both limits fall 5 cycles after ACTIVE.
- R6: Successive ACTIVE commands are at least ceil(tRC/period) cycles apart and at least ceil(tRP/period) cycles after the PRECHARGE between them. With requests held back to back they are exactly 8 cycles apart at the defaults.
- R7: `req_ready` is low from acceptance until the sequencer is idle and both the row-cycle and precharge windows have run out; at the defaults it returns 7 cycles after ACTIVE. `req_valid` while not ready produces no ACTIVE.
- R8: Every cycle that carries no ACTIVE, READ or PRECHARGE shows NOP. `sd_cke` is always high and `sd_dqm` always low.
- R9: `done` is a single-cycle pulse, issued once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request will be taken on this edge |
| req_bank | input | BANK_W | Bank to read |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Column to read |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | DQ_W | Word captured for the completed read |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Row / column address bus |
| sd_dqm | output | 1 | Data mask, held low |
| sd_dq | input | DQ_W | Read data from memory |

## Verification
The hardest case to reach is the next ACTIVE being held back by the row-cycle window rather than by the precharge window. It only shows when a second request is already waiting at the moment the first one frees the bus. The bench keeps `req_valid` high across two requests and changes the payload in the cycle after the first is accepted. It then measures the gap between the two ACTIVE commands. A behavioural memory model on the bench side flags any premature READ, PRECHARGE or ACTIVE. It returns an address-derived word exactly at the CAS latency, so a capture that lands one edge early or late yields a wrong word.

// File: rtl/sdram_rd_pkg.sv
// Shared types and helpers for the single-word SDRAM read sequencer.
// Assumes command encodings follow the usual {cs_n,ras_n,cas_n,we_n} map.
package sdram_rd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_PRE = 4'b0010
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RCD,
        ST_CAS,
        ST_RAS
    } seq_st_e;

    // Address bit that selects auto precharge / all-bank precharge.
    localparam int unsigned AP_BIT = 10;

    // Timer slots in the timer bank of the top module.
    localparam int unsigned TMR_RCD = 0;
    localparam int unsigned TMR_RAS = 1;
    localparam int unsigned TMR_RC  = 2;
    localparam int unsigned TMR_RP  = 3;
    localparam int unsigned TMR_CAS = 4;
    localparam int unsigned TMR_N   = 5;

    // Cycles needed to cover t_ps at clock period clk_ps, rounded up, at least 1.
    function automatic int unsigned span_cycles(int unsigned t_ps, int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
// Down-counter that enforces a minimum gap of SPAN clock edges.
// After `start` on edge E, `expired` is high again from edge E+SPAN onward.
// Assumes SPAN >= 1.
module sdr_gap_timer #(
    parameter int unsigned SPAN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int unsigned LOADV = SPAN - 1;
    localparam int unsigned CW    = (LOADV < 2) ? 1 : $clog2(LOADV + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(LOADV);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdr_cmd_fsm.sv
// Command sequencer: ACTIVE -> READ (auto precharge off) -> capture -> PRECHARGE.
// Every step is gated by the timer flags it receives. Outputs are registered.
// Assumes COL_W <= AP_BIT and ROW_W <= ADDR_W.
module sdr_cmd_fsm
    import sdram_rd_pkg::*;
#(
    parameter int unsigned BANK_W = 2,
    parameter int unsigned ROW_W  = 12,
    parameter int unsigned COL_W  = 9,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [TMR_N-1:0]  tmr_zero,
    output logic              req_ready,
    output logic [TMR_N-1:0]  tmr_start,
    output logic              cap_en,
    output sd_cmd_e           cmd_q,
    output logic [BANK_W-1:0] ba_q,
    output logic [ADDR_W-1:0] addr_q
);
    seq_st_e           st_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic              accept, issue_rd, data_now, issue_pre;

    // Step decisions from the current state and the timer flags.
    always_comb begin
        req_ready = (st_q == ST_IDLE) && tmr_zero[TMR_RP] && tmr_zero[TMR_RC];
        accept    = req_valid && req_ready;
        issue_rd  = (st_q == ST_RCD) && tmr_zero[TMR_RCD];
        data_now  = (st_q == ST_CAS) && tmr_zero[TMR_CAS];
        issue_pre = tmr_zero[TMR_RAS] && (data_now || (st_q == ST_RAS));
        cap_en    = data_now;
        tmr_start = '0;
        tmr_start[TMR_RCD] = accept;
        tmr_start[TMR_RAS] = accept;
        tmr_start[TMR_RC]  = accept;
        tmr_start[TMR_RP]  = issue_pre;
        tmr_start[TMR_CAS] = issue_rd;
    end

    // State progression through one read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else begin
            case (st_q)
                ST_IDLE: if (accept)   st_q <= ST_RCD;
                ST_RCD:  if (issue_rd) st_q <= ST_CAS;
                ST_CAS:  if (data_now) st_q <= issue_pre ? ST_IDLE : ST_RAS;
                default: if (issue_pre) st_q <= ST_IDLE;
            endcase
        end
    end

    // Hold the bank and column of the request in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            col_q  <= '0;
        end else if (accept) begin
            bank_q <= req_bank;
            col_q  <= req_col;
        end
    end

    // Registered command bus, NOP in every slot without a command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
        end else if (accept) begin
            cmd_q  <= CMD_ACT;
            ba_q   <= req_bank;
            addr_q <= ADDR_W'(req_row);
        end else if (issue_rd) begin
            cmd_q  <= CMD_RD;
            ba_q   <= bank_q;
            addr_q <= ADDR_W'(col_q);
        end else if (issue_pre) begin
            cmd_q  <= CMD_PRE;
            ba_q   <= bank_q;
            addr_q <= '0;
        end else begin
            cmd_q  <= CMD_NOP;
        end
    end
endmodule

// File: rtl/sdr_rd_capture.sv
// Registers the read word on the capture edge and raises a one-cycle done pulse.
// Assumes DQ is valid around the edge on which cap_en is high.
module sdr_rd_capture #(
    parameter int unsigned DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [DQ_W-1:0] dq,
    output logic            done,
    output logic [DQ_W-1:0] data
);
    // Sample DQ and pulse done for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            data <= '0;
        end else begin
            done <= cap_en;
            if (cap_en)
                data <= dq;
        end
    end
endmodule

// File: rtl/sdram_rd_seq.sv
// Top of the single-word SDRAM read sequencer. Converts picosecond minimums to
// cycle counts, runs one gap timer per constraint and drives the command bus.
// Assumes burst length 1 and that mode/refresh/init are handled elsewhere.
module sdram_rd_seq
    import sdram_rd_pkg::*;
#(
    parameter int unsigned CLK_PS  = 7500,
    parameter int unsigned TRCD_PS = 15000,
    parameter int unsigned TRAS_PS = 37000,
    parameter int unsigned TRP_PS  = 15000,
    parameter int unsigned TRC_PS  = 60000,
    parameter int unsigned CAS_LAT = 2,
    parameter int unsigned BANK_W  = 2,
    parameter int unsigned ROW_W   = 12,
    parameter int unsigned COL_W   = 9,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DQ_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              done,
    output logic [DQ_W-1:0]   done_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_dqm,
    input  logic [DQ_W-1:0]   sd_dq
);
    localparam int unsigned TRCD_CYC = span_cycles(TRCD_PS, CLK_PS);
    localparam int unsigned TRAS_CYC = span_cycles(TRAS_PS, CLK_PS);
    localparam int unsigned TRP_CYC  = span_cycles(TRP_PS, CLK_PS);
    localparam int unsigned TRC_CYC  = span_cycles(TRC_PS, CLK_PS);
    localparam int unsigned CAP_CYC  = CAS_LAT + 1;
    localparam int unsigned SPANS [TMR_N] = '{TRCD_CYC, TRAS_CYC, TRC_CYC, TRP_CYC, CAP_CYC};

    logic [TMR_N-1:0] tmr_start, tmr_zero;
    logic             cap_en;
    sd_cmd_e          cmd_q;

    // One gap timer per timing constraint.
    for (genvar i = 0; i < TMR_N; i++) begin : g_tmr
        sdr_gap_timer #(.SPAN(SPANS[i])) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (tmr_start[i]),
            .expired (tmr_zero[i])
        );
    end

    sdr_cmd_fsm #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_col   (req_col),
        .tmr_zero  (tmr_zero),
        .req_ready (req_ready),
        .tmr_start (tmr_start),
        .cap_en    (cap_en),
        .cmd_q     (cmd_q),
        .ba_q      (sd_ba),
        .addr_q    (sd_addr)
    );

    sdr_rd_capture #(.DQ_W(DQ_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .dq     (sd_dq),
        .done   (done),
        .data   (done_data)
    );

    // Split the command code onto the strobe pins; CKE and DQM are static.
    assign sd_cs_n  = cmd_q[3];
    assign sd_ras_n = cmd_q[2];
    assign sd_cas_n = cmd_q[1];
    assign sd_we_n  = cmd_q[0];
    assign sd_cke   = 1'b1;
    assign sd_dqm   = 1'b0;
endmodule

// File: rtl/sdram_rd_seq_chk.sv
// Protocol checker for sdram_rd_seq, observing only its ports.
// Tracks cycles since the last ACTIVE, READ and PRECHARGE with saturating counters.
module sdram_rd_seq_chk
    import sdram_rd_pkg::*;
#(
    parameter int unsigned CLK_PS  = 7500,
    parameter int unsigned TRCD_PS = 15000,
    parameter int unsigned TRAS_PS = 37000,
    parameter int unsigned TRP_PS  = 15000,
    parameter int unsigned TRC_PS  = 60000,
    parameter int unsigned CAS_LAT = 2,
    parameter int unsigned BANK_W  = 2,
    parameter int unsigned ROW_W   = 12,
    parameter int unsigned ADDR_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [BANK_W-1:0] req_bank,
    input logic [ROW_W-1:0]  req_row,
    input logic              done,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BANK_W-1:0] sd_ba,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              sd_dqm
);
    localparam logic [7:0] RCD_C = 8'(span_cycles(TRCD_PS, CLK_PS));
    localparam logic [7:0] RAS_C = 8'(span_cycles(TRAS_PS, CLK_PS));
    localparam logic [7:0] RP_C  = 8'(span_cycles(TRP_PS, CLK_PS));
    localparam logic [7:0] RC_C  = 8'(span_cycles(TRC_PS, CLK_PS));
    localparam logic [7:0] CAP_C = 8'(CAS_LAT + 1);

    logic [3:0]        bus;
    logic [7:0]        since_act, since_rd, since_pre;
    logic              act_seen, rd_seen, pre_seen;
    logic [BANK_W-1:0] act_bank;

    assign bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // Cycle distances to the most recent commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= '0; since_rd <= '0; since_pre <= '0;
            act_seen  <= 1'b0; rd_seen <= 1'b0; pre_seen <= 1'b0;
            act_bank  <= '0;
        end else begin
            since_act <= (bus == CMD_ACT) ? 8'd1 : ((since_act == 8'hFF) ? since_act : since_act + 8'd1);
            since_rd  <= (bus == CMD_RD)  ? 8'd1 : ((since_rd  == 8'hFF) ? since_rd  : since_rd  + 8'd1);
            since_pre <= (bus == CMD_PRE) ? 8'd1 : ((since_pre == 8'hFF) ? since_pre : since_pre + 8'd1);
            if (bus == CMD_ACT) begin act_seen <= 1'b1; act_bank <= sd_ba; end
            if (bus == CMD_RD)  rd_seen  <= 1'b1;
            if (bus == CMD_PRE) pre_seen <= 1'b1;
        end
    end

    a_r2_act_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus == CMD_ACT && sd_ba == $past(req_bank)
                                      && sd_addr == ADDR_W'($past(req_row))));

    a_r3_read_at_rcd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == CMD_RD) |-> (act_seen && since_act == RCD_C && sd_ba == act_bank && !sd_addr[AP_BIT]));

    a_r4_done_at_cas: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_seen && since_rd == CAP_C));

    a_r5_pre_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == CMD_PRE) |-> (act_seen && since_act >= RAS_C && rd_seen && since_rd >= CAP_C
                              && since_rd < since_act && sd_ba == act_bank && !sd_addr[AP_BIT]));

    a_r6_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == CMD_ACT && act_seen) |-> (since_act >= RC_C && pre_seen
                                          && since_pre < since_act && since_pre >= RP_C));

    a_r7_busy_no_act: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (bus != CMD_ACT));

    a_r8_static_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cke && !sd_dqm && !sd_cs_n));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind sdram_rd_seq sdram_rd_seq_chk #(
    .CLK_PS  (CLK_PS),
    .TRCD_PS (TRCD_PS),
    .TRAS_PS (TRAS_PS),
    .TRP_PS  (TRP_PS),
    .TRC_PS  (TRC_PS),
    .CAS_LAT (CAS_LAT),
    .BANK_W  (BANK_W),
    .ROW_W   (ROW_W),
    .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/sdram_rd_seq_bench.sv
// Directed bench for sdram_rd_seq with a behavioural SDRAM read model.
module sdram_rd_seq_bench;
    localparam int CLK_PS = 8000;
    localparam int BW = 2, RW = 12, CW = 9, AW = 12, DW = 16, CL = 2;
    // Expected cycle counts, ceil(ns / 8 ns).
    localparam int E_RCD = (15000 + CLK_PS - 1) / CLK_PS;
    localparam int E_RAS = (37000 + CLK_PS - 1) / CLK_PS;
    localparam int E_RP  = (15000 + CLK_PS - 1) / CLK_PS;
    localparam int E_RC  = (60000 + CLK_PS - 1) / CLK_PS;
    localparam int E_DONE = E_RCD + CL + 1;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101, C_PRE = 4'b0010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic req_ready, done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm;
    logic [DW-1:0] done_data;
    logic [BW-1:0] sd_ba;
    logic [AW-1:0] sd_addr;
    logic [DW-1:0] sd_dq = 'x;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_rd_seq #(.CLK_PS(CLK_PS)) u_sdram_rd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .done(done), .done_data(done_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq(sd_dq)
    );

    function automatic logic [3:0] bus();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    function automatic logic [DW-1:0] word_of(input int b, input int r, input int c);
        return DW'((r * 13) ^ (c << 3) ^ (b * 16'h4001)) ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Behavioural memory: timing violations and CAS-latency data return.
    int last_act = -1000, last_pre = -1000, last_rd = -1000;
    bit any_act = 1'b0;
    int open_row [4];
    int pend = 0;
    logic [DW-1:0] pdata;
    always @(negedge clk) begin
        sd_dq = (pend == 1) ? pdata : 'x;
        if (pend > 0) pend = pend - 1;
        if (rst_n) begin
            case (bus())
                C_ACT: begin
                    if (any_act) begin
                        chk(cyc - last_act >= E_RC, "R6", "model ACT-ACT gap", cyc - last_act, E_RC);
                        chk(cyc - last_pre >= E_RP, "R6", "model PRE-ACT gap", cyc - last_pre, E_RP);
                    end
                    any_act = 1'b1;
                    last_act = cyc;
                    open_row[sd_ba] = int'(sd_addr);
                end
                C_RD: begin
                    chk(cyc - last_act >= E_RCD, "R3", "model ACT-READ gap", cyc - last_act, E_RCD);
                    last_rd = cyc;
                    pdata = word_of(int'(sd_ba), open_row[sd_ba], int'(sd_addr[CW-1:0]));
                    pend = CL;
                end
                C_PRE: begin
                    chk(cyc - last_act >= E_RAS, "R5", "model ACT-PRE gap", cyc - last_act, E_RAS);
                    last_pre = cyc;
                end
                default: ;
            endcase
        end
    end

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    // Per-offset expectation for a lone read whose ACTIVE is at offset 0.
    task automatic expect_slot(input int k, input int b, input int r, input int c);
        if (k == 0) begin
            chk(bus() == C_ACT && sd_ba == BW'(b) && sd_addr == AW'(r), "R2", "ACTIVE bank/row",
                int'({bus(), sd_ba, sd_addr}), int'({C_ACT, BW'(b), AW'(r)}));
        end else if (k == E_RCD) begin
            chk(bus() == C_RD && sd_ba == BW'(b) && sd_addr == AW'(c), "R3", "READ bank/col, A10 low",
                int'({bus(), sd_ba, sd_addr}), int'({C_RD, BW'(b), AW'(c)}));
        end else if (k == E_DONE) begin
            chk(done && done_data == word_of(b, r, c), "R4", "done with captured word",
                int'({done, done_data}), int'({1'b1, word_of(b, r, c)}));
            chk(bus() == C_PRE && sd_ba == BW'(b) && !sd_addr[10], "R5", "PRECHARGE bank, A10 low",
                int'({bus(), sd_ba, sd_addr}), int'({C_PRE, BW'(b), AW'(0)}));
        end else begin
            chk(bus() == C_NOP, "R8", "NOP between commands", int'(bus()), int'(C_NOP));
            chk(!done, "R9", "done low outside pulse", int'(done), 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus() == C_NOP, "R1", "bus NOP after reset", int'(bus()), int'(C_NOP));
        chk(!done, "R1", "done low after reset", int'(done), 0);
        chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
        chk(sd_cke && !sd_dqm, "R8", "cke/dqm levels", int'({sd_cke, sd_dqm}), 2);
    endtask

    task automatic t_single(input int b, input int r, input int c);
        wait_ready();
        req_valid = 1'b1; req_bank = BW'(b); req_row = RW'(r); req_col = CW'(c);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 8; k++) begin
            expect_slot(k, b, r, c);
            if (k < 7) @(negedge clk);
        end
    endtask

    task automatic t_busy_ignored();
        wait_ready();
        req_valid = 1'b1; req_bank = 2'd1; req_row = 12'h321; req_col = 9'h0F0;
        @(negedge clk);
        req_bank = 2'd2; req_row = 12'h777; req_col = 9'h011;
        for (int k = 0; k < 12; k++) begin
            if (k <= 7) expect_slot(k, 1, 'h321, 'h0F0);
            else chk(bus() == C_NOP, "R7", "no ACTIVE from busy request", int'(bus()), int'(C_NOP));
            if (k < 7) chk(!req_ready, "R7", "ready low while busy", int'(req_ready), 0);
            if (k == 7) chk(req_ready, "R7", "ready back after windows", int'(req_ready), 1);
            if (k == 6) req_valid = 1'b0;
            if (k < 11) @(negedge clk);
        end
    endtask

    task automatic t_back_to_back();
        int gap;
        wait_ready();
        req_valid = 1'b1; req_bank = 2'd2; req_row = 12'h0A5; req_col = 9'h1C3;
        @(negedge clk);
        gap = -1;
        req_bank = 2'd0; req_row = 12'hF0F; req_col = 9'h02A;
        for (int k = 0; k < 14; k++) begin
            if (k < E_RC) expect_slot(k, 2, 'h0A5, 'h1C3);
            if (k > 0 && bus() == C_ACT && gap < 0) begin
                gap = k;
                req_valid = 1'b0;
            end
            if (k == E_RC + E_DONE)
                chk(done && done_data == word_of(0, 'hF0F, 'h02A), "R4", "second word",
                    int'(done_data), int'(word_of(0, 'hF0F, 'h02A)));
            if (k < 13) @(negedge clk);
        end
        chk(gap == E_RC, "R6", "ACTIVE-to-ACTIVE spacing", gap, E_RC);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_single(0, 0, 0);
        t_single(3, 'hFFF, 'h1FF);
        t_single(1, 'hAAA, 'h155);
        t_busy_ignored();
        t_back_to_back();
        t_single(2, 'h123, 'h0AB);
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule